// File: doc/BRIEF.md
# UART Automatic Flow Control Unit

This block decides, cycle by cycle, whether a UART may send data and which handshake signals it presents to the far end. It sits between the receive and transmit FIFOs (128 entries each) and the serial shifter. It watches the receive FIFO fill level against two programmable thresholds, the modem inputs for clear-to-send and data-set-ready, and every character the receiver delivers. It also watches the transmitter's empty indication.

From these inputs it drives the active-low request-to-send and data-terminal-ready pins. It also gives the shifter a data-permit level, which the shifter samples only when it is about to start a new character. A character already in flight therefore always completes. For in-band flow control the block raises one-shot requests to insert the programmed Xon or Xoff character. Each request is held until the shifter acknowledges it.

In half-duplex RS485 mode, the data-terminal-ready pin and a separate driver-enable output follow the transmitter's empty flag instead of the thresholds. Two status flags are visible to the register block: the link is paused by the remote end, and an Xoff has been sent. The modem inputs are assumed to be synchronised before they reach this block.

Top module: `uart_flow_ctrl`

## Requirements
- R1: After reset, rtsN and dtrN are 0 (asserted), txDataPermit is 1, xonReq and xoffReq are 0, and both status flags are 0.
- R2: With autoRtsEn set, rtsN goes to 1 on the clock after rxLevel >= hiThresh. It stays 1 while rxLevel is between the thresholds. It returns to 0 on the clock after rxLevel < loThresh.
- R3: With autoDtrEn set and rs485En clear, dtrN follows the same threshold state as rtsN.
- R4: With autoCtsEn set, ctsN = 1 forces txDataPermit to 0 in the same cycle. With autoDsrEn set, dsrN = 1 does the same.
- R5: With inbandRxEn set, a valid received character equal to xoffChar sets pausedByRemote on the next clock, and txDataPermit goes to 0. A character equal to xonChar clears pausedByRemote. Other characters change nothing. With inbandRxEn clear, Xoff characters are ignored.
- R6: With inbandTxEn set, xoffReq rises once when rxLevel reaches hiThresh while no Xoff is outstanding. It stays high until flowCharAck. It is not raised again while the level stays high.
- R7: xonReq rises when rxLevel < loThresh only if an Xoff was sent before (xoffSent = 1), and it is held until flowCharAck. Otherwise no Xon is requested.
- R8: xonReq and xoffReq do not depend on ctsN or dsrN, and they are never both high.
- R9: With rs485En set, dtrN equals txEmpty, and drvEn is 1 exactly while txEmpty is 0.
- R10: Status output xoffSent is 1 from the Xoff request until the matching Xon request. pausedByRemote reflects the remote pause state.
- R11: With autoRtsEn clear, rtsN stays 0 whatever rxLevel is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rxLevel | input | 8 | Receive FIFO fill level, 0..128 |
| hiThresh | input | 7 | Upper threshold |
| loThresh | input | 7 | Lower threshold |
| autoRtsEn | input | 1 | Threshold-driven RTS enable |
| autoDtrEn | input | 1 | Threshold-driven DTR enable |
| autoCtsEn | input | 1 | CTS gating enable |
| autoDsrEn | input | 1 | DSR gating enable |
| inbandRxEn | input | 1 | Act on received Xon/Xoff |
| inbandTxEn | input | 1 | Request Xon/Xoff insertion |
| rs485En | input | 1 | Half-duplex driver control mode |
| ctsN | input | 1 | Clear-to-send, active low |
| dsrN | input | 1 | Data-set-ready, active low |
| rxCharValid | input | 1 | Received character strobe |
| rxChar | input | 8 | Received character |
| xonChar | input | 8 | Programmed Xon character |
| xoffChar | input | 8 | Programmed Xoff character |
| txEmpty | input | 1 | Transmitter fully empty |
| flowCharAck | input | 1 | Shifter accepted the pending flow character |
| rtsN | output | 1 | Request-to-send, active low |
| dtrN | output | 1 | Data-terminal-ready, active low |
| drvEn | output | 1 | RS485 line driver enable |
| txDataPermit | output | 1 | Shifter may start a data character |
| xonReq | output | 1 | Insert Xon request |
| xoffReq | output | 1 | Insert Xoff request |
| pausedByRemote | output | 1 | Status: remote sent Xoff |
| xoffSent | output | 1 | Status: Xoff outstanding |

## Verification
The fill level is swept up through the upper threshold, held between the thresholds, placed exactly on the lower threshold and then one below it. This separates a hysteresis band from a single-compare design, and `>=` from `>` at each edge. Received streams of Xoff, an ordinary character and Xon show that only the programmed codes change the pause state. CTS and DSR are toggled one at a time to show each gates data independently. A flow-character request is then raised while CTS blocks the link, which shows the bypass. Directed cases cover a low level with no Xoff sent, the auto features disabled, and RS485 mode.

// File: rtl/flow_pkg.sv
package flow_pkg;
  typedef struct packed {
    logic atHigh;
    logic belowLow;
    logic gotXon;
    logic gotXoff;
    logic linesOk;
  } flowStrobes_t;
endpackage

// File: rtl/flow_datapath.sv
module flow_datapath
  import flow_pkg::*;
#(
  parameter int LVL_W  = 8,
  parameter int TH_W   = 7,
  parameter int CHAR_W = 8
) (
  input  logic [LVL_W-1:0]  rxLevel,
  input  logic [TH_W-1:0]   hiThresh,
  input  logic [TH_W-1:0]   loThresh,
  input  logic              rxCharValid,
  input  logic [CHAR_W-1:0] rxChar,
  input  logic [CHAR_W-1:0] xonChar,
  input  logic [CHAR_W-1:0] xoffChar,
  input  logic              autoCtsEn,
  input  logic              autoDsrEn,
  input  logic              ctsN,
  input  logic              dsrN,
  output flowStrobes_t      strobes
);
  localparam int PAD = LVL_W - TH_W;
  logic [LVL_W-1:0] hiExt, loExt;

  assign hiExt = {{PAD{1'b0}}, hiThresh};
  assign loExt = {{PAD{1'b0}}, loThresh};

  always_comb begin
    strobes.atHigh   = (rxLevel >= hiExt);
    strobes.belowLow = (rxLevel < loExt);
    strobes.gotXoff  = rxCharValid && (rxChar == xoffChar);
    strobes.gotXon   = rxCharValid && (rxChar == xonChar) && !strobes.gotXoff;
    strobes.linesOk  = (!autoCtsEn || !ctsN) && (!autoDsrEn || !dsrN);
  end
endmodule

// File: rtl/flow_control.sv
module flow_control
  import flow_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  flowStrobes_t strobes,
  input  logic         autoRtsEn,
  input  logic         autoDtrEn,
  input  logic         inbandRxEn,
  input  logic         inbandTxEn,
  input  logic         rs485En,
  input  logic         txEmpty,
  input  logic         flowCharAck,
  output logic         rtsN,
  output logic         dtrN,
  output logic         drvEn,
  output logic         txDataPermit,
  output logic         xonReq,
  output logic         xoffReq,
  output logic         pausedByRemote,
  output logic         xoffSent
);
  logic rxFull;
  logic needXoff, needXon;

  assign needXoff = inbandTxEn && strobes.atHigh && !xoffSent;
  assign needXon  = xoffSent && strobes.belowLow && !strobes.atHigh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxFull <= 1'b0;
    end else if (strobes.atHigh) begin
      rxFull <= 1'b1;
    end else if (strobes.belowLow) begin
      rxFull <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pausedByRemote <= 1'b0;
    end else if (!inbandRxEn) begin
      pausedByRemote <= 1'b0;
    end else if (strobes.gotXoff) begin
      pausedByRemote <= 1'b1;
    end else if (strobes.gotXon) begin
      pausedByRemote <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xoffSent <= 1'b0;
      xoffReq  <= 1'b0;
      xonReq   <= 1'b0;
    end else if (needXoff) begin
      xoffSent <= 1'b1;
      xoffReq  <= 1'b1;
      xonReq   <= 1'b0;
    end else if (needXon) begin
      xoffSent <= 1'b0;
      xonReq   <= 1'b1;
      xoffReq  <= 1'b0;
    end else if (flowCharAck) begin
      xoffReq  <= 1'b0;
      xonReq   <= 1'b0;
    end
  end

  assign rtsN         = autoRtsEn && rxFull;
  assign dtrN         = rs485En ? txEmpty : (autoDtrEn && rxFull);
  assign drvEn        = rs485En && !txEmpty;
  assign txDataPermit = !pausedByRemote && strobes.linesOk;
endmodule

// File: rtl/uart_flow_ctrl.sv
module uart_flow_ctrl
  import flow_pkg::*;
#(
  parameter int DEPTH  = 128,
  parameter int CHAR_W = 8,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int TH_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LVL_W-1:0]  rxLevel,
  input  logic [TH_W-1:0]   hiThresh,
  input  logic [TH_W-1:0]   loThresh,
  input  logic              autoRtsEn,
  input  logic              autoDtrEn,
  input  logic              autoCtsEn,
  input  logic              autoDsrEn,
  input  logic              inbandRxEn,
  input  logic              inbandTxEn,
  input  logic              rs485En,
  input  logic              ctsN,
  input  logic              dsrN,
  input  logic              rxCharValid,
  input  logic [CHAR_W-1:0] rxChar,
  input  logic [CHAR_W-1:0] xonChar,
  input  logic [CHAR_W-1:0] xoffChar,
  input  logic              txEmpty,
  input  logic              flowCharAck,
  output logic              rtsN,
  output logic              dtrN,
  output logic              drvEn,
  output logic              txDataPermit,
  output logic              xonReq,
  output logic              xoffReq,
  output logic              pausedByRemote,
  output logic              xoffSent
);
  flowStrobes_t strobes;

  flow_datapath #(.LVL_W(LVL_W), .TH_W(TH_W), .CHAR_W(CHAR_W)) dpath (
    .rxLevel(rxLevel), .hiThresh(hiThresh), .loThresh(loThresh),
    .rxCharValid(rxCharValid), .rxChar(rxChar),
    .xonChar(xonChar), .xoffChar(xoffChar),
    .autoCtsEn(autoCtsEn), .autoDsrEn(autoDsrEn),
    .ctsN(ctsN), .dsrN(dsrN), .strobes(strobes)
  );

  flow_control ctrl (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .autoRtsEn(autoRtsEn), .autoDtrEn(autoDtrEn),
    .inbandRxEn(inbandRxEn), .inbandTxEn(inbandTxEn),
    .rs485En(rs485En), .txEmpty(txEmpty), .flowCharAck(flowCharAck),
    .rtsN(rtsN), .dtrN(dtrN), .drvEn(drvEn), .txDataPermit(txDataPermit),
    .xonReq(xonReq), .xoffReq(xoffReq),
    .pausedByRemote(pausedByRemote), .xoffSent(xoffSent)
  );
endmodule

// File: rtl/uart_flow_ctrl_chk.sv
module uart_flow_ctrl_chk #(
  parameter int LVL_W  = 8,
  parameter int TH_W   = 7,
  parameter int CHAR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [LVL_W-1:0]  rxLevel,
  input logic [TH_W-1:0]   hiThresh,
  input logic              autoRtsEn,
  input logic              autoCtsEn,
  input logic              autoDsrEn,
  input logic              inbandRxEn,
  input logic              ctsN,
  input logic              dsrN,
  input logic              rxCharValid,
  input logic [CHAR_W-1:0] rxChar,
  input logic [CHAR_W-1:0] xoffChar,
  input logic              rtsN,
  input logic              txDataPermit,
  input logic              xonReq,
  input logic              xoffReq,
  input logic              xoffSent
);
  // R2
  rts_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (autoRtsEn && rxLevel >= {{(LVL_W-TH_W){1'b0}}, hiThresh}) |=> (rtsN || !autoRtsEn));

  // R4
  lines_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((autoCtsEn && ctsN) || (autoDsrEn && dsrN)) |-> !txDataPermit);

  // R5
  remote_pause_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inbandRxEn && rxCharValid && rxChar == xoffChar) |=> !txDataPermit);

  // R8
  single_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(xonReq && xoffReq));

  // R7
  xon_after_xoff_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(xonReq) |-> $past(xoffSent));

  // R6
  xoff_sets_sent_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(xoffReq) |-> xoffSent);
endmodule

bind uart_flow_ctrl uart_flow_ctrl_chk #(.LVL_W(LVL_W), .TH_W(TH_W), .CHAR_W(CHAR_W)) chk (
  .clk(clk), .rstN(rstN), .rxLevel(rxLevel), .hiThresh(hiThresh),
  .autoRtsEn(autoRtsEn), .autoCtsEn(autoCtsEn), .autoDsrEn(autoDsrEn),
  .inbandRxEn(inbandRxEn), .ctsN(ctsN), .dsrN(dsrN),
  .rxCharValid(rxCharValid), .rxChar(rxChar), .xoffChar(xoffChar),
  .rtsN(rtsN), .txDataPermit(txDataPermit), .xonReq(xonReq),
  .xoffReq(xoffReq), .xoffSent(xoffSent)
);

// File: tb/uart_flow_ctrl_test.sv
module uart_flow_ctrl_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] rxLevel = 8'd0;
  logic [6:0] hiThresh = 7'd100, loThresh = 7'd20;
  logic autoRtsEn = 1'b1, autoDtrEn = 1'b1, autoCtsEn = 1'b1, autoDsrEn = 1'b1;
  logic inbandRxEn = 1'b1, inbandTxEn = 1'b1, rs485En = 1'b0;
  logic ctsN = 1'b0, dsrN = 1'b0, rxCharValid = 1'b0;
  logic [7:0] rxChar = 8'h00, xonChar = 8'h11, xoffChar = 8'h13;
  logic txEmpty = 1'b1, flowCharAck = 1'b0;
  logic rtsN, dtrN, drvEn, txDataPermit, xonReq, xoffReq, pausedByRemote, xoffSent;

  int runCount = 0;
  int failCount = 0;

  always #2 clk = ~clk;

  uart_flow_ctrl uut (.*);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    runCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // stimulus: lvl, vld, chr, cts, dsr, ack | expected: rts, permit, xoffReq, xonReq, paused, sent
  localparam int NV = 15;
  localparam logic [25:0] VEC [NV] = '{
    {8'd50,  1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 6'b010000},
    {8'd100, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 6'b111001},
    {8'd100, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 6'b110001},
    {8'd60,  1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 6'b110001},
    {8'd20,  1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 6'b110001},
    {8'd19,  1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 6'b010100},
    {8'd19,  1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 6'b010000},
    {8'd10,  1'b1, 8'h13, 1'b0, 1'b0, 1'b0, 6'b000010},
    {8'd10,  1'b1, 8'h41, 1'b0, 1'b0, 1'b0, 6'b000010},
    {8'd10,  1'b1, 8'h11, 1'b0, 1'b0, 1'b0, 6'b010000},
    {8'd10,  1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 6'b000000},
    {8'd10,  1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 6'b000000},
    {8'd10,  1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 6'b010000},
    {8'd127, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 6'b101001},
    {8'd127, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 6'b110001}
  };

  task automatic stepCycle();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #40000;
    failCount++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", runCount, failCount);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 rtsN", rtsN, 0);
    check("R1 dtrN", dtrN, 0);
    check("R1 permit", txDataPermit, 1);
    check("R1 reqs", {xonReq, xoffReq}, 0);
    check("R1 status", {pausedByRemote, xoffSent}, 0);
    @(negedge clk) rstN = 1'b1;

    // R7: level below lower threshold with no Xoff sent -> no Xon
    rxLevel = 8'd5;
    stepCycle();
    check("R7 no xon without xoff", xonReq, 0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {rxLevel, rxCharValid, rxChar, ctsN, dsrN, flowCharAck} = VEC[i][25:6];
      stepCycle();
      check($sformatf("R2 rtsN v%0d", i), rtsN, VEC[i][5]);
      check($sformatf("R3 dtrN v%0d", i), dtrN, VEC[i][5]);
      check($sformatf("R4/R5 permit v%0d", i), txDataPermit, VEC[i][4]);
      check($sformatf("R6/R8 xoffReq v%0d", i), xoffReq, VEC[i][3]);
      check($sformatf("R7 xonReq v%0d", i), xonReq, VEC[i][2]);
      check($sformatf("R10 paused v%0d", i), pausedByRemote, VEC[i][1]);
      check($sformatf("R10 xoffSent v%0d", i), xoffSent, VEC[i][0]);
    end

    // R5: Xoff ignored when in-band receive is disabled
    @(negedge clk);
    flowCharAck = 1'b0; ctsN = 1'b0; inbandRxEn = 1'b0;
    rxCharValid = 1'b1; rxChar = 8'h13;
    stepCycle();
    @(negedge clk) rxCharValid = 1'b0;
    stepCycle();
    check("R5 xoff ignored", txDataPermit, 1);
    check("R5 paused clear", pausedByRemote, 0);

    // R11: auto RTS disabled keeps rtsN asserted with FIFO full
    @(negedge clk) autoRtsEn = 1'b0; rxLevel = 8'd128;
    stepCycle();
    check("R11 rtsN stays low", rtsN, 0);

    // R9: RS485 mode drives DTR# and driver enable from txEmpty
    @(negedge clk) rs485En = 1'b1; txEmpty = 1'b0;
    #1;
    check("R9 dtrN busy", dtrN, 0);
    check("R9 drvEn busy", drvEn, 1);
    @(negedge clk) txEmpty = 1'b1;
    #1;
    check("R9 dtrN empty", dtrN, 1);
    check("R9 drvEn empty", drvEn, 0);

    $display("[TB] %0d tests run, %0d failed", runCount, failCount);
    $finish;
  end
endmodule